// File: doc/BRIEF.md
# Monitor Channel Internal Calibration Unit

This block turns raw converter samples from five monitor channels into calibrated results. Channel 0 is the die temperature, channel 1 the supply voltage, and channels 2 to 4 three external monitors. Each incoming sample arrives with a channel index and a valid strobe. The block corrects the sample with that channel's constants and saturates it to a 13-bit range. It then stores the value left-justified in a 16-bit result word, and the host reads that word back one byte at a time.

The four non-temperature channels follow the same path. The raw code is scaled by an unsigned fractional gain. A signed offset is added. The sum is then shifted right by a per-channel amount. The temperature channel gets only its signed offset and keeps a two's complement result. The constants come in as static input vectors, and their storage is outside this block.

Top module: `mon_cal_unit`

## Requirements
- R1: After reset, all five result words read as zero.
- R2: For channels 1 to 4, the corrected value is floor(raw × gain / 2^15) + offset. raw and gain are unsigned 16-bit, and offset is signed 16-bit. Gain for channel c sits in `cal_gain[16(c-1) +: 16]`, so 8000h is unity. Offset for channel c sits in `cal_offs[16c +: 16]`.
- R3: For channels 1 to 4, the corrected value is shifted right arithmetically by the 3-bit amount in `cal_shift[3(c-1) +: 3]` before saturation.
- R4: Results for channels 1 to 4 saturate: a negative value gives 0, and a value above 8191 gives 8191.
- R5: The channel 0 result is raw + offset, with raw taken as signed 16-bit and offset from `cal_offs[15:0]`. No gain and no shift are applied, and the result is two's complement.
- R6: The channel 0 result saturates to the range -4096 to +4095.
- R7: Each result word holds the 13-bit value in bits 15:3, and bits 2:0 are zero. Channel k occupies byte addresses 60h+2k (bits 15:8) and 61h+2k (bits 7:0).
- R8: A sample presented with `smp_valid` high is visible on the read port after the next rising clock edge. Both bytes of the word change in that same edge. Strobes on consecutive cycles are all taken.
- R9: With `smp_valid` low, or with a channel index of 5 to 7, no result word changes.
- R10: Reads at addresses outside 60h to 69h return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 3 | Channel index of the sample (0 temperature, 1 supply, 2..4 monitors) |
| smp_raw | input | 16 | Raw converter code |
| cal_gain | input | 64 | Gain constants for channels 1..4 |
| cal_offs | input | 80 | Offset constants for channels 0..4 |
| cal_shift | input | 12 | Right-shift amounts for channels 1..4 |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte, combinational from the result words |

## Verification
The corners that are hardest to reach are the saturation edges. Each one needs a specific combination of raw code, gain, offset and shift, and uniform random stimulus almost never lands on it. One case is a negative offset that stays negative through the shift. Another is full-scale gain times full-scale raw plus a positive offset. A third is the temperature sum overflowing either end of the signed range. The stimulus is therefore organised in phases. Each phase loads constants aimed at one corner and then sends raw codes that straddle it. A final phase sends strobes on every cycle across all channels, with invalid indices mixed in. Every readable byte, including addresses just outside the window, is compared against the model after every edge.

// File: rtl/mcal_pkg.sv
package mcal_pkg;

  // Channel numbering; the result word order follows it.
  localparam int unsigned MCAL_NCH  = 5;
  localparam int unsigned MCAL_CH_W = 3;

  typedef enum logic [MCAL_CH_W-1:0] {
    CH_TEMP = 3'd0,
    CH_VSUP = 3'd1,
    CH_MON1 = 3'd2,
    CH_MON2 = 3'd3,
    CH_MON3 = 3'd4
  } mcal_chan_e;

  function automatic int unsigned mcal_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mcal_rst_sync.sv
module mcal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mcal_trim.sv
// Gain/offset/shift arithmetic for one sample; purely combinational.
module mcal_trim #(
  parameter int unsigned RAW_W     = 16,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 15,
  parameter int unsigned OFFS_W    = 16,
  parameter int unsigned SHIFT_W   = 3,
  parameter int unsigned COR_W     = 19
) (
  input  logic                     is_temp,
  input  logic [RAW_W-1:0]         raw,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [OFFS_W-1:0]        offs,
  input  logic [SHIFT_W-1:0]       shamt,
  output logic signed [COR_W-1:0]  cor
);

  localparam int unsigned PROD_W = RAW_W + GAIN_W;

  logic [PROD_W-1:0]        prod;
  logic signed [COR_W-1:0]  scl_x;
  logic signed [COR_W-1:0]  offs_x;
  logic signed [COR_W-1:0]  raw_x;
  logic signed [COR_W-1:0]  gain_sum;
  logic signed [COR_W-1:0]  gain_shf;
  logic signed [COR_W-1:0]  temp_sum;

  always_comb begin
    prod     = PROD_W'(raw) * PROD_W'(gain);
    // Drop the fraction bits; the remaining magnitude always fits COR_W.
    scl_x    = COR_W'(prod >> GAIN_FRAC);
    offs_x   = {{(COR_W-OFFS_W){offs[OFFS_W-1]}}, offs};
    raw_x    = {{(COR_W-RAW_W){raw[RAW_W-1]}}, raw};
    gain_sum = scl_x + offs_x;
    gain_shf = gain_sum >>> shamt;
    temp_sum = raw_x + offs_x;
    cor      = is_temp ? temp_sum : gain_shf;
  end

endmodule

// File: rtl/mcal_clamp.sv
// Saturates the corrected value to the result range and left-justifies it.
module mcal_clamp #(
  parameter int unsigned COR_W  = 19,
  parameter int unsigned RES_W  = 13,
  parameter int unsigned WORD_W = 16
) (
  input  logic                     is_temp,
  input  logic signed [COR_W-1:0]  cor,
  output logic [WORD_W-1:0]        word
);

  localparam int unsigned PAD_W = WORD_W - RES_W;
  localparam logic signed [COR_W-1:0] U_MAX = COR_W'((1 << RES_W) - 1);
  localparam logic signed [COR_W-1:0] S_MAX = COR_W'((1 << (RES_W-1)) - 1);
  localparam logic signed [COR_W-1:0] S_MIN = -COR_W'(1 << (RES_W-1));

  logic [RES_W-1:0] val;

  always_comb begin
    if (is_temp) begin
      if (cor > S_MAX) begin
        val = S_MAX[RES_W-1:0];
      end else if (cor < S_MIN) begin
        val = S_MIN[RES_W-1:0];
      end else begin
        val = cor[RES_W-1:0];
      end
    end else begin
      if (cor < 0) begin
        val = '0;
      end else if (cor > U_MAX) begin
        val = U_MAX[RES_W-1:0];
      end else begin
        val = cor[RES_W-1:0];
      end
    end
    word = {val, {PAD_W{1'b0}}};
  end

endmodule

// File: rtl/mcal_bank.sv
// Result words, one register per channel, with a byte-wide read port.
module mcal_bank #(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'h60
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         wr_sel,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic [NCH*WORD_W-1:0]   res_flat
);

  localparam int unsigned BPW = WORD_W / 8;

  for (genvar k = 0; k < NCH; k++) begin : g_slot
    logic              slot_en;
    logic [WORD_W-1:0] slot_d;
    logic [WORD_W-1:0] slot_q;

    always_comb begin
      slot_en = wr_en && (wr_sel == CH_W'(k));
      slot_d  = slot_en ? wr_word : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (slot_en) begin
        slot_q <= slot_d;
      end
    end

    assign res_flat[k*WORD_W +: WORD_W] = slot_q;
  end

  logic [ADDR_W-1:0] rd_off;

  always_comb begin
    rd_off  = rd_addr - ADDR_W'(BASE);
    rd_data = '0;
    for (int k = 0; k < int'(NCH); k++) begin
      for (int b = 0; b < int'(BPW); b++) begin
        // Lower address carries the more significant byte.
        if (rd_off == ADDR_W'(k*BPW + b)) begin
          rd_data = res_flat[k*WORD_W + (BPW-1-b)*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/mon_cal_unit.sv
module mon_cal_unit
  import mcal_pkg::*;
#(
  parameter int unsigned RAW_W     = 16,
  parameter int unsigned GAIN_W    = 16,
  parameter int unsigned GAIN_FRAC = 15,
  parameter int unsigned OFFS_W    = 16,
  parameter int unsigned SHIFT_W   = 3,
  parameter int unsigned RES_W     = 13,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [7:0]  BASE      = 8'h60
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smp_valid,
  input  logic [MCAL_CH_W-1:0]           smp_chan,
  input  logic [RAW_W-1:0]               smp_raw,
  input  logic [(MCAL_NCH-1)*GAIN_W-1:0] cal_gain,
  input  logic [MCAL_NCH*OFFS_W-1:0]     cal_offs,
  input  logic [(MCAL_NCH-1)*SHIFT_W-1:0] cal_shift,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [7:0]                     rd_data
);

  localparam int unsigned NCH   = MCAL_NCH;
  localparam int unsigned NTRIM = NCH - 1;
  localparam int unsigned SCL_W = RAW_W + GAIN_W - GAIN_FRAC;
  localparam int unsigned COR_W = mcal_max(SCL_W, mcal_max(OFFS_W, RAW_W)) + 2;

  logic                    rst_s_n;
  logic                    chan_ok;
  logic                    is_temp;
  logic                    wr_en;
  logic [GAIN_W-1:0]       gain_sel;
  logic [OFFS_W-1:0]       offs_sel;
  logic [SHIFT_W-1:0]      shift_sel;
  logic signed [COR_W-1:0] cor;
  logic [WORD_W-1:0]       cal_word;
  logic [NCH*WORD_W-1:0]   res_flat;

  mcal_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  // Constant selection by channel index.
  always_comb begin
    chan_ok   = (smp_chan < MCAL_CH_W'(NCH));
    is_temp   = (smp_chan == CH_TEMP);
    wr_en     = smp_valid && chan_ok;
    gain_sel  = '0;
    shift_sel = '0;
    offs_sel  = '0;
    for (int i = 0; i < int'(NTRIM); i++) begin
      if (smp_chan == MCAL_CH_W'(i + 1)) begin
        gain_sel  = cal_gain[i*GAIN_W +: GAIN_W];
        shift_sel = cal_shift[i*SHIFT_W +: SHIFT_W];
      end
    end
    for (int k = 0; k < int'(NCH); k++) begin
      if (smp_chan == MCAL_CH_W'(k)) begin
        offs_sel = cal_offs[k*OFFS_W +: OFFS_W];
      end
    end
  end

  mcal_trim #(
    .RAW_W(RAW_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
    .OFFS_W(OFFS_W), .SHIFT_W(SHIFT_W), .COR_W(COR_W)
  ) u_trim (
    .is_temp (is_temp),
    .raw     (smp_raw),
    .gain    (gain_sel),
    .offs    (offs_sel),
    .shamt   (shift_sel),
    .cor     (cor)
  );

  mcal_clamp #(.COR_W(COR_W), .RES_W(RES_W), .WORD_W(WORD_W)) u_clamp (
    .is_temp (is_temp),
    .cor     (cor),
    .word    (cal_word)
  );

  mcal_bank #(
    .NCH(NCH), .CH_W(MCAL_CH_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wr_en    (wr_en),
    .wr_sel   (smp_chan),
    .wr_word  (cal_word),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .res_flat (res_flat)
  );

endmodule

// File: rtl/mcal_chk.sv
module mcal_chk #(
  parameter int unsigned NCH    = 5,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned RAW_W  = 16,
  parameter int unsigned OFFS_W = 16,
  parameter int unsigned RES_W  = 13,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 8,
  parameter logic [7:0]  BASE   = 8'h60
) (
  input logic                  clk,
  input logic                  rst_sn,
  input logic                  smp_valid,
  input logic [CH_W-1:0]       smp_chan,
  input logic [RAW_W-1:0]      smp_raw,
  input logic [NCH*OFFS_W-1:0] cal_offs,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic [7:0]            rd_data,
  input logic [NCH*WORD_W-1:0] res_flat
);

  localparam int unsigned PAD_W = WORD_W - RES_W;

  // R9 / R8: a word only moves when its own channel was strobed.
  for (genvar k = 0; k < NCH; k++) begin : g_hold
    p_hold_unselected_r9: assert property (@(posedge clk) disable iff (!rst_sn)
      !(smp_valid && smp_chan == CH_W'(k)) |=> $stable(res_flat[k*WORD_W +: WORD_W]))
      else $error("p_hold_unselected_r9 channel %0d", k);
  end

  // R4: zero raw with a negative offset must clamp to zero whatever the shift.
  for (genvar k = 1; k < NCH; k++) begin : g_negclamp
    p_neg_clamp_r4: assert property (@(posedge clk) disable iff (!rst_sn)
      (smp_valid && smp_chan == CH_W'(k) && smp_raw == '0 &&
       cal_offs[k*OFFS_W + OFFS_W - 1]) |=> (res_flat[k*WORD_W +: WORD_W] == '0))
      else $error("p_neg_clamp_r4 channel %0d", k);
  end

  // R5: zero temperature offset with an in-range raw code passes it through.
  p_temp_pass_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_valid && smp_chan == '0 && cal_offs[OFFS_W-1:0] == '0 &&
     ((&smp_raw[RAW_W-1:RES_W-1]) || !(|smp_raw[RAW_W-1:RES_W-1])))
    |=> (res_flat[WORD_W-1:0] == {$past(smp_raw[RES_W-1:0]), {PAD_W{1'b0}}}))
    else $error("p_temp_pass_r5");

  // R10: reads outside the window are zero.
  p_outside_zero_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_addr < ADDR_W'(BASE) || rd_addr >= ADDR_W'(BASE) + ADDR_W'(2*NCH)) |-> (rd_data == 8'h00))
    else $error("p_outside_zero_r10");

endmodule

bind mon_cal_unit mcal_chk #(
  .NCH(NCH), .CH_W(mcal_pkg::MCAL_CH_W), .RAW_W(RAW_W), .OFFS_W(OFFS_W),
  .RES_W(RES_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk       (clk),
  .rst_sn    (rst_s_n),
  .smp_valid (smp_valid),
  .smp_chan  (smp_chan),
  .smp_raw   (smp_raw),
  .cal_offs  (cal_offs),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .res_flat  (res_flat)
);

// File: tb/sim_mon_cal_unit.sv
`timescale 1ns/100ps
module sim_mon_cal_unit;

  localparam int NCH  = 5;
  localparam int BASE = 8'h60;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [15:0] smp_raw;
  logic [63:0] cal_gain;
  logic [79:0] cal_offs;
  logic [11:0] cal_shift;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;

  int    n_checks;
  int    n_errors;
  bit    done;
  string tag;

  logic [15:0] g_c  [1:4];
  logic [15:0] o_c  [0:4];
  logic [2:0]  sh_c [1:4];
  logic [15:0] exp_w [0:4];

  mon_cal_unit u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_raw(smp_raw), .cal_gain(cal_gain), .cal_offs(cal_offs),
    .cal_shift(cal_shift), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] model(input int ch, input logic [15:0] raw,
                                        input logic [15:0] g, input logic [15:0] o,
                                        input logic [2:0] sh);
    longint s;
    if (ch == 0) begin
      s = longint'($signed(raw)) + longint'($signed(o));
      if (s > 4095) s = 4095;
      if (s < -4096) s = -4096;
    end else begin
      s = (longint'(raw) * longint'(g)) >>> 15;
      s = s + longint'($signed(o));
      s = s >>> sh;
      if (s < 0) s = 0;
      if (s > 8191) s = 8191;
    end
    return 16'((s & 64'h1FFF) << 3);
  endfunction

  task automatic load_cal();
    for (int i = 1; i <= 4; i++) begin
      cal_gain[(i-1)*16 +: 16] = g_c[i];
      cal_shift[(i-1)*3 +: 3]  = sh_c[i];
    end
    for (int k = 0; k < NCH; k++) cal_offs[k*16 +: 16] = o_c[k];
  endtask

  task automatic check_all();
    logic [7:0] e;
    for (int a = BASE - 2; a < BASE + 2*NCH + 2; a++) begin
      rd_addr = 8'(a);
      #0.5;
      if (a < BASE || a >= BASE + 2*NCH) begin
        e = 8'h00;
        n_checks++;
        if (rd_data !== e) begin
          n_errors++;
          $display("FAIL R10 addr %02h: got %02h expected %02h", a, rd_data, e);
        end
      end else begin
        e = ((a - BASE) % 2 == 0) ? exp_w[(a-BASE)/2][15:8] : exp_w[(a-BASE)/2][7:0];
        n_checks++;
        if (rd_data !== e) begin
          n_errors++;
          $display("FAIL %s addr %02h: got %02h expected %02h", tag, a, rd_data, e);
        end
        if ((a - BASE) % 2 == 1) begin
          n_checks++;
          if (rd_data[2:0] !== 3'b000) begin
            n_errors++;
            $display("FAIL R7 addr %02h low bits: got %0b expected 000", a, rd_data[2:0]);
          end
        end
      end
    end
  endtask

  // One sample per call: drive at the falling edge, model it, check after the rising edge.
  task automatic send(input bit v, input int ch, input logic [15:0] raw);
    smp_valid = v;
    smp_chan  = 3'(ch);
    smp_raw   = raw;
    if (v && ch < NCH) begin
      if (ch == 0) exp_w[0] = model(0, raw, 16'h0, o_c[0], 3'd0);
      else         exp_w[ch] = model(ch, raw, g_c[ch], o_c[ch], sh_c[ch]);
    end
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 0; tag = "R1";
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_raw = '0; rd_addr = '0;
    for (int k = 0; k < NCH; k++) begin o_c[k] = '0; exp_w[k] = '0; end
    for (int i = 1; i <= 4; i++) begin g_c[i] = 16'h8000; sh_c[i] = '0; end
    load_cal();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all();
    send(0, 0, 16'h0);

    // R2: gain and offset, no shift
    tag = "R2";
    for (int n = 0; n < 24; n++) begin
      for (int i = 1; i <= 4; i++) begin
        g_c[i]  = (n < 4) ? 16'h8000 : 16'($urandom());
        o_c[i]  = 16'($signed(12'($urandom())));
        sh_c[i] = '0;
      end
      load_cal();
      send(1, 1 + (n % 4), 16'($urandom()) >> 2);
    end

    // R3: shifts
    tag = "R3";
    for (int n = 0; n < 24; n++) begin
      for (int i = 1; i <= 4; i++) begin
        g_c[i] = 16'($urandom()); o_c[i] = 16'($urandom() % 4096); sh_c[i] = 3'($urandom());
      end
      load_cal();
      send(1, 1 + (n % 4), 16'($urandom()));
    end

    // R4: saturation at both ends
    tag = "R4";
    for (int i = 1; i <= 4; i++) begin
      g_c[i] = 16'hFFFF; o_c[i] = 16'h8000; sh_c[i] = 3'(i);
      load_cal();
      send(1, i, 16'h0000);
      send(1, i, 16'h0100);
      o_c[i] = 16'd100; sh_c[i] = 3'd0;
      load_cal();
      send(1, i, 16'hFFFF);
      g_c[i] = 16'h8000; o_c[i] = 16'h0000;
      load_cal();
      send(1, i, 16'd8191);
      send(1, i, 16'd8192);
    end

    // R5: temperature, offset only
    tag = "R5";
    for (int n = 0; n < 16; n++) begin
      o_c[0] = (n < 4) ? 16'h0 : 16'($signed(11'($urandom())));
      for (int i = 1; i <= 4; i++) begin g_c[i] = 16'($urandom()); sh_c[i] = 3'($urandom()); end
      load_cal();
      send(1, 0, 16'($signed(12'($urandom()))));
    end

    // R6: temperature limits
    tag = "R6";
    o_c[0] = 16'h7FFF; load_cal(); send(1, 0, 16'h7FFF);
    o_c[0] = 16'h8000; load_cal(); send(1, 0, 16'h8000);
    o_c[0] = 16'h0001; load_cal(); send(1, 0, 16'd4095);
    o_c[0] = 16'hFFFF; load_cal(); send(1, 0, 16'hF000);
    o_c[0] = 16'h0000; load_cal(); send(1, 0, 16'hEFFF);

    // R8: back-to-back strobes over every channel
    tag = "R8";
    for (int n = 0; n < 40; n++) begin
      for (int k = 0; k < NCH; k++) o_c[k] = 16'($urandom());
      for (int i = 1; i <= 4; i++) begin g_c[i] = 16'($urandom()); sh_c[i] = 3'($urandom()); end
      load_cal();
      send(1, n % NCH, 16'($urandom()));
    end

    // R9: idle strobe and out-of-range channel indices
    tag = "R9";
    for (int n = 0; n < 24; n++) begin
      for (int k = 0; k < NCH; k++) o_c[k] = 16'($urandom());
      load_cal();
      if (n % 2 == 0) send(0, n % NCH, 16'($urandom()));
      else            send(1, 5 + (n % 3), 16'($urandom()));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule